// File: doc/BRIEF.md
# Buck Channel Enable Arbiter

This block decides, cycle by cycle, whether one buck regulator channel is asked to run. It takes two control sources. One is a register enable bit that software writes. The other is an external enable pin, already debounced elsewhere. A pin-select bit chooses which source is in charge. On top of both, the device power state can veto the request.

When the pin is in charge, edges of the pin do not act at once. A rising edge switches the channel on only after a start-up wait. A falling edge switches it off only after a separate shutdown wait. Each wait is set by a 4-bit code and timed by an external tick strobe. A pending wait is dropped if the pin returns to its old level before the wait runs out.

Writes to the register enable bit or to the pin-select bit bypass both waits. They take effect in the same cycle.

Top module: `vreg_on_arbiter`

## Requirements
- R1: `dev_state_i` values 2'd1 (standby) and 2'd2 (active) permit the channel. Values 2'd0 and 2'd3 force `reg_on_o` low in the same cycle, whatever the other inputs are.
- R2: While `reg_en_i` is 0, `reg_on_o` is 0 regardless of `pin_sel_i` and `pin_i`.
- R3: With `reg_en_i`=1 and `pin_sel_i`=0 in a permitted state, `reg_on_o` is 1 and `pin_i` has no effect on it.
- R4: With `reg_en_i`=1 and `pin_sel_i`=1 (pin mode) in a permitted state, `reg_on_o` settles to the level of `pin_i`: 1 for high, 0 for low.
- R5: Take a pin-mode rise of `pin_i` with `tick_i` held at 1. `reg_on_o` rises after clock edge number `rise_code_i`*TICKS_PER_STEP+1, counting the first edge that samples the new pin level as edge 1. A code of 0 therefore takes effect at that first edge.
- R6: A pin-mode fall of `pin_i` follows the same rule, using `fall_code_i` and switching `reg_on_o` to 0.
- R7: A change of `reg_en_i` or `pin_sel_i` changes `reg_on_o` in the same cycle, without either wait. On entry to pin mode, `reg_on_o` takes the pin level that was present while outside pin mode, at once.
- R8: If `pin_i` returns to its previous level before a pending wait expires, the pending transition is cancelled and `reg_on_o` keeps its value. A later edge starts a full new wait.
- R9: A pending wait advances only on cycles with `tick_i`=1. While `tick_i` stays 0, the pending transition never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timing strobe; each high cycle is one tick of the wait |
| reg_en_i | input | 1 | Register enable bit |
| pin_sel_i | input | 1 | 1 hands control to the pin when the enable bit is set |
| pin_i | input | 1 | Debounced external enable pin |
| dev_state_i | input | 2 | Device power state code |
| rise_code_i | input | CODE_W | Start-up wait code |
| fall_code_i | input | CODE_W | Shutdown wait code |
| reg_on_o | output | 1 | Regulator run request |

## Verification
The only hidden state is the delayed pin level and the tick counter. A wrong delayed level shows at `reg_on_o` in pin mode as soon as the pin is stable. A wrong counter shows as an output edge one or more cycles early or late. For this reason, the rise and fall sweeps sample the output on the cycle just before the expected switch and on the cycle of the switch, for every code. A counter that is not cleared would show as a shortened wait after a cancel or after a trip out of pin mode. Both of these are driven and timed to the exact cycle.

// File: rtl/vreg_on_pkg.sv
// Shared definitions for the buck channel enable arbiter.
// Assumes the device state is carried as a 2-bit code.
package vreg_on_pkg;

    typedef enum logic [1:0] {
        DS_OFF     = 2'd0,
        DS_STANDBY = 2'd1,
        DS_ACTIVE  = 2'd2,
        DS_FAULT   = 2'd3
    } dev_state_e;

    // True in the states where the channel may run.
    function automatic logic state_permits(input logic [1:0] st);
        return (st == DS_STANDBY) || (st == DS_ACTIVE);
    endfunction

endpackage

// File: rtl/vreg_delay_timer.sv
// Counts tick strobes up to a target and flags when the target is reached.
// Assumes the owner clears it whenever no wait is pending or a wait completes.
// A target of zero reads as done at once.
module vreg_delay_timer #(
    parameter int CNT_W   = 6,
    parameter int MAX_CNT = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // Done once the counted ticks reach the target.
    always_comb done_o = (cnt_q >= target_i);

    // Advance on ticks until done; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_i) && !$past(clear_i)) |-> $stable(cnt_q));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CNT));

endmodule

// File: rtl/vreg_pin_tracker.sv
// Holds the delayed pin-mode level. Outside pin mode it copies the pin at
// once. In pin mode it moves toward the pin only after the wait chosen by
// the edge direction. Assumes pin_i is already synchronous and debounced.
module vreg_pin_tracker #(
    parameter int CODE_W         = 4,
    parameter int TICKS_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pin_mode_i,
    input  logic              pin_i,
    input  logic [CODE_W-1:0] rise_code_i,
    input  logic [CODE_W-1:0] fall_code_i,
    output logic              level_o
);

    localparam int MAX_CNT = ((1 << CODE_W) - 1) * TICKS_PER_STEP;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic              level_q;
    logic              mismatch;
    logic              done;
    logic              clear;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  target;

    // Pick the wait for the direction the pin is moving in.
    always_comb begin
        mismatch = (pin_i != level_q);
        code     = pin_i ? rise_code_i : fall_code_i;
        target   = CNT_W'(code) * CNT_W'(TICKS_PER_STEP);
        clear    = !pin_mode_i || !mismatch || done;
    end

    vreg_delay_timer #(
        .CNT_W   (CNT_W),
        .MAX_CNT (MAX_CNT)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .tick_i   (tick_i),
        .target_i (target),
        .done_o   (done)
    );

    // Follow the pin directly outside pin mode, after the wait inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (!pin_mode_i || (mismatch && done)) begin
            level_q <= pin_i;
        end
    end

    always_comb level_o = level_q;

    // R4
    toward_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pin_mode_i) && (level_q != $past(level_q))) |-> (level_q == $past(pin_i)));

    // R7
    outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode_i |=> (level_q == $past(pin_i)));

    // R8
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode_i && !mismatch) |=> $stable(level_q));

endmodule

// File: rtl/vreg_on_arbiter.sv
// Top of the buck channel enable arbiter. Combines the device-state veto,
// the register enable bit and the delayed pin level into one run request.
// Register-side changes reach the output in the same cycle.
module vreg_on_arbiter
    import vreg_on_pkg::*;
#(
    parameter int CODE_W         = 4,
    parameter int TICKS_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_en_i,
    input  logic              pin_sel_i,
    input  logic              pin_i,
    input  logic [1:0]        dev_state_i,
    input  logic [CODE_W-1:0] rise_code_i,
    input  logic [CODE_W-1:0] fall_code_i,
    output logic              reg_on_o
);

    logic permit;
    logic pin_mode;
    logic pin_level;

    // Decode the state veto and the active control source.
    always_comb begin
        permit   = state_permits(dev_state_i);
        pin_mode = reg_en_i && pin_sel_i;
    end

    vreg_pin_tracker #(
        .CODE_W         (CODE_W),
        .TICKS_PER_STEP (TICKS_PER_STEP)
    ) i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .pin_mode_i  (pin_mode),
        .pin_i       (pin_i),
        .rise_code_i (rise_code_i),
        .fall_code_i (fall_code_i),
        .level_o     (pin_level)
    );

    // Form the run request from the selected source.
    always_comb reg_on_o = permit && reg_en_i && (!pin_sel_i || pin_level);

    // R1
    state_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_permits(dev_state_i) |-> !reg_on_o);

    // R2
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en_i |-> !reg_on_o);

    // R3
    reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en_i && !pin_sel_i && state_permits(dev_state_i)) |-> reg_on_o);

endmodule

// File: tb/test_vreg_on_arbiter.sv
`timescale 1ns/1ps
module test_vreg_on_arbiter;

    localparam int CW  = 4;
    localparam int TPS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b1;
    logic          reg_en_i = 1'b0;
    logic          pin_sel_i = 1'b0;
    logic          pin_i = 1'b0;
    logic [1:0]    dev_state_i = 2'd2;
    logic [CW-1:0] rise_code_i = '0;
    logic [CW-1:0] fall_code_i = '0;
    logic          reg_on_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    vreg_on_arbiter #(.CODE_W(CW), .TICKS_PER_STEP(TPS)) i_vreg_on_arbiter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_en_i(reg_en_i),
        .pin_sel_i(pin_sel_i), .pin_i(pin_i), .dev_state_i(dev_state_i),
        .rise_code_i(rise_code_i), .fall_code_i(fall_code_i), .reg_on_o(reg_on_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (reg_on_o !== exp) begin
            n_fail++;
            $display("FAIL %s: reg_on_o=%0b expected %0b at %0t", req, reg_on_o, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run=hung expected=done");
        finish_run();
    end

    initial begin
        step(3);
        check(1'b0, "reset");
        rst_n = 1'b1;
        step(1);
        check(1'b0, "reset");

        // R1 R2 R3 R4: static sweep over state, enable, select and pin
        for (int s = 0; s < 4; s++)
            for (int e = 0; e < 2; e++)
                for (int m = 0; m < 2; m++)
                    for (int p = 0; p < 2; p++) begin
                        dev_state_i = 2'(s); reg_en_i = e[0];
                        pin_sel_i = m[0]; pin_i = p[0];
                        step(2);
                        check(((s == 1) || (s == 2)) && e[0] && (!m[0] || p[0]),
                              (s == 0 || s == 3) ? "R1" : (!e[0] ? "R2" : (!m[0] ? "R3" : "R4")));
                    end

        // R1: veto acts in the same cycle
        dev_state_i = 2'd2; reg_en_i = 1'b1; pin_sel_i = 1'b0;
        step(1);
        dev_state_i = 2'd3; #1;
        check(1'b0, "R1");
        dev_state_i = 2'd1; #1;
        check(1'b1, "R1");

        // R5 R6: every rise and fall code
        pin_sel_i = 1'b1; pin_i = 1'b0;
        step(2);
        for (int c = 0; c < 16; c++) begin
            rise_code_i = 4'(c);
            pin_i = 1'b1;
            if (c > 0) begin
                step(c * TPS);
                check(1'b0, "R5");
                step(1);
            end else begin
                step(1);
            end
            check(1'b1, "R5");
            fall_code_i = 4'(c);
            pin_i = 1'b0;
            if (c > 0) begin
                step(c * TPS);
                check(1'b1, "R6");
                step(1);
            end else begin
                step(1);
            end
            check(1'b0, "R6");
        end

        // R8: cancel then fresh full wait
        rise_code_i = 4'd3;
        pin_i = 1'b1;
        step(5);
        pin_i = 1'b0;
        step(20);
        check(1'b0, "R8");
        pin_i = 1'b1;
        step(12);
        check(1'b0, "R8");
        step(1);
        check(1'b1, "R8");

        // R7: register-side changes bypass the waits
        fall_code_i = 4'd15;
        reg_en_i = 1'b0; #1;
        check(1'b0, "R7");
        reg_en_i = 1'b1; #1;
        check(1'b1, "R7");
        pin_i = 1'b0;
        step(3);
        pin_sel_i = 1'b0; #1;
        check(1'b1, "R7");
        step(2);
        pin_sel_i = 1'b1; #1;
        check(1'b0, "R7");
        pin_i = 1'b1;
        step(12);
        check(1'b0, "R7");
        step(1);
        check(1'b1, "R7");

        // R9: no ticks, no progress
        fall_code_i = 4'd1;
        tick_i = 1'b0;
        pin_i = 1'b0;
        step(50);
        check(1'b1, "R9");
        tick_i = 1'b1;
        step(TPS);
        check(1'b1, "R9");
        step(1);
        check(1'b0, "R9");

        finish_run();
    end

endmodule